// File: doc/BRIEF.md
# Operating-Mode Register and Memory Decoder

This block holds the processor's 24-bit operating-mode control register and turns each of the three address buses (X data, Y data, program) into a one-hot region select plus an "external access" flag. The register takes its three mode bits from the mode pins on the last clock of reset. After that, software changes the register only through update operations: direct write, AND mask, OR mask, and single-bit set, clear and toggle.

Two register bits gate the data decode. The data-ROM enable bit maps internal ROM over the 256-word window that sits just above the internal RAM. The Y-disable bit sends the whole Y space off-chip, but leaves the X peripheral window internal. The program decode maps 512 words of internal RAM unless the mode bits select the mode with no internal program RAM. A status flag rises after reset to show that the mode pins now serve as interrupt inputs.

The decode is combinational from the address and the current register. A register update therefore reaches the selects in the cycle after it is issued.

Top module: `opmode_mem_decode`

## Requirements
- R1: Only register bits 0 (mode A), 1 (mode B), 2 (data-ROM enable), 3 (Y disable), 4 (mode C) and 6 (stop delay) are implemented, a mask of 0x00005F. All other bits always read zero, whatever the operation writes.
- R2: On every clock where rst_n is low, bits 0, 1 and 4 load from mode_pin_a, mode_pin_b and mode_pin_c. The register therefore holds the pin values from the last reset cycle. While rst_n is high, the pins have no effect on the register.
- R3: On every clock where rst_n is low, the data-ROM enable, Y-disable and stop-delay bits clear.
- R4: When rst_n is high and upd_en is 1, upd_op selects the update, which lands on the next clock edge and reaches the decode outputs from then on. The codes are: 0 write upd_data; 1 AND with upd_data; 2 OR with upd_data; 3 set bit upd_bit; 4 clear bit upd_bit; 5 toggle bit upd_bit. An upd_bit of 24 or more selects no bit.
- R5: upd_op codes 6 and 7 leave the register unchanged. Any update requested while rst_n is low has no effect.
- R6: X addresses 0x0000–0x00FF select RAM. X addresses 0x0100–0x01FF select ROM when the data-ROM enable bit is 1 and are external otherwise. All other X addresses below 0xFFC0 are external.
- R7: X addresses 0xFFC0–0xFFFF always select the peripheral region, and x_ext is 0 there.
- R8: When the Y-disable bit is 1, every Y address is external. Otherwise Y decodes like X (RAM, then ROM gated by the data-ROM enable bit), except that it has no peripheral window.
- R9: Program addresses 0x0000–0x01FF select RAM and all others are external. The exception is mode B = 1 with mode A = 0: in that mode every program address is external.
- R10: Each select output is one-hot: bit 0 RAM, bit 1 ROM, bit 2 peripheral, bit 3 external. Each *_ext flag equals bit 3 of its select.
- R11: pins_are_irq is 0 after any clock where rst_n is low and 1 after any clock where rst_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin_a | input | 1 | Mode pin captured into bit 0 during reset |
| mode_pin_b | input | 1 | Mode pin captured into bit 1 during reset |
| mode_pin_c | input | 1 | Mode pin captured into bit 4 during reset |
| upd_en | input | 1 | Apply an update this cycle |
| upd_op | input | 3 | Update operation code |
| upd_data | input | 24 | Write value or mask |
| upd_bit | input | 5 | Bit index for set, clear and toggle |
| omr_q | output | 24 | Current register value |
| pins_are_irq | output | 1 | Mode pins now act as interrupt inputs |
| x_addr | input | 16 | X data address |
| x_sel | output | 4 | X region select, one-hot |
| x_ext | output | 1 | X access is external |
| y_addr | input | 16 | Y data address |
| y_sel | output | 4 | Y region select, one-hot |
| y_ext | output | 1 | Y access is external |
| p_addr | input | 16 | Program address |
| p_sel | output | 4 | Program region select, one-hot |
| p_ext | output | 1 | Program access is external |

## Verification
The hardest situation to reach is the boundary between reset and run, for two reasons. The mode bits must match the pins of the final reset cycle. And pin changes, or an update held on during reset, must leave no trace.

The bench reaches it by asserting reset with all eight pin patterns and holding an update request active through reset. It then flips the pins after release and reads the register back.

The gated decode is covered by a full sweep of all three address spaces. The sweep runs under register values that cover every data-ROM-enable/Y-disable pair and every mode-A/mode-B pair.

// File: rtl/opmode_pkg.sv
// Shared constants for the operating-mode register and memory decoder.
// Assumes a 24-bit register with six implemented bits.
package opmode_pkg;
    localparam int OMR_W  = 24;
    localparam int OMR_BW = $clog2(OMR_W);
    localparam logic [OMR_W-1:0] OMR_IMPL_MASK = 24'h00005F;

    localparam int B_MA = 0;
    localparam int B_MB = 1;
    localparam int B_DE = 2;
    localparam int B_YD = 3;
    localparam int B_MC = 4;
    localparam int B_SD = 6;

    localparam logic [2:0] UPD_WRITE = 3'd0;
    localparam logic [2:0] UPD_AND   = 3'd1;
    localparam logic [2:0] UPD_OR    = 3'd2;
    localparam logic [2:0] UPD_BSET  = 3'd3;
    localparam logic [2:0] UPD_BCLR  = 3'd4;
    localparam logic [2:0] UPD_BFLIP = 3'd5;

    localparam int SEL_W      = 4;
    localparam int SEL_RAM    = 0;
    localparam int SEL_ROM    = 1;
    localparam int SEL_PERIPH = 2;
    localparam int SEL_EXT    = 3;
endpackage

// File: rtl/opmode_reg.sv
// Operating-mode register. During reset it samples the mode pins into the
// mode bits and clears the gating bits. After reset it changes only
// through the update port. It also raises a flag once the pins have been
// released for interrupt use. Assumes a synchronous active-low reset.
module opmode_reg
    import opmode_pkg::*;
#(
    parameter int W  = OMR_W,
    parameter int BW = OMR_BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_a,
    input  logic          pin_b,
    input  logic          pin_c,
    input  logic          upd_en,
    input  logic [2:0]    upd_op,
    input  logic [W-1:0]  upd_data,
    input  logic [BW-1:0] upd_bit,
    output logic [W-1:0]  omr_q,
    output logic          pins_irq
);
    localparam logic [W-1:0] IMPL = W'(OMR_IMPL_MASK);

    logic [W-1:0] bit_sel;
    logic [W-1:0] upd_next;
    logic [W-1:0] rst_val;

    // Reset image: mode bits from the pins, everything else zero.
    always_comb begin
        rst_val       = '0;
        rst_val[B_MA] = pin_a;
        rst_val[B_MB] = pin_b;
        rst_val[B_MC] = pin_c;
    end

    // Next value for each update operation. An index past the width selects nothing.
    always_comb begin
        bit_sel = W'(1) << upd_bit;
        case (upd_op)
            UPD_WRITE: upd_next = upd_data;
            UPD_AND:   upd_next = omr_q & upd_data;
            UPD_OR:    upd_next = omr_q | upd_data;
            UPD_BSET:  upd_next = omr_q | bit_sel;
            UPD_BCLR:  upd_next = omr_q & ~bit_sel;
            UPD_BFLIP: upd_next = omr_q ^ bit_sel;
            default:   upd_next = omr_q;
        endcase
    end

    // Register state: reset capture, or the masked update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            omr_q <= rst_val;
        end else if (upd_en) begin
            omr_q <= upd_next & IMPL;
        end
    end

    // Flag showing that the mode pins now act as interrupt inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_irq <= 1'b0;
        end else begin
            pins_irq <= 1'b1;
        end
    end
endmodule

// File: rtl/addr_space_dec.sv
// Address decoder for one memory space. It produces a one-hot region
// select: RAM at the bottom, an optional gated ROM window, and an optional
// peripheral window at the top (peripheral takes priority). space_off
// forces every address external. Purely combinational.
module addr_space_dec
    import opmode_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int RAM_WORDS   = 256,
    parameter bit HAS_ROM     = 1'b1,
    parameter int ROM_BASE    = 256,
    parameter int ROM_WORDS   = 256,
    parameter bit HAS_PERIPH  = 1'b1,
    parameter int PERIPH_BASE = 'hFFC0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              space_off,
    input  logic              rom_en,
    output logic [SEL_W-1:0]  sel,
    output logic              ext
);
    localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_WORDS - 1);
    localparam logic [ADDR_W-1:0] ROM_LO   = ADDR_W'(ROM_BASE);
    localparam logic [ADDR_W-1:0] ROM_HI   = ADDR_W'(ROM_BASE + ROM_WORDS - 1);
    localparam logic [ADDR_W-1:0] PER_LO   = ADDR_W'(PERIPH_BASE);

    logic ram_hit;
    logic rom_hit;
    logic per_hit;

    // RAM window starts at address zero.
    assign ram_hit = (addr <= RAM_LAST);

    generate
        if (HAS_ROM) begin : g_rom
            // ROM window counts only when enabled.
            assign rom_hit = rom_en && (addr >= ROM_LO) && (addr <= ROM_HI);
        end else begin : g_no_rom
            logic unused_rom_en;
            assign unused_rom_en = rom_en;
            assign rom_hit = 1'b0;
        end
        if (HAS_PERIPH) begin : g_per
            // Peripheral window runs to the top of the space.
            assign per_hit = (addr >= PER_LO);
        end else begin : g_no_per
            assign per_hit = 1'b0;
        end
    endgenerate

    // Prioritised region choice into a one-hot select.
    always_comb begin
        sel = '0;
        if (space_off)    sel[SEL_EXT]    = 1'b1;
        else if (per_hit) sel[SEL_PERIPH] = 1'b1;
        else if (ram_hit) sel[SEL_RAM]    = 1'b1;
        else if (rom_hit) sel[SEL_ROM]    = 1'b1;
        else              sel[SEL_EXT]    = 1'b1;
    end

    assign ext = sel[SEL_EXT];
endmodule

// File: rtl/opmode_mem_decode.sv
// Top: operating-mode register plus the X, Y and program decoders. The
// decode reads the registered bits, so an update shows on the selects one
// cycle after it is issued. Assumes a synchronous active-low reset.
module opmode_mem_decode
    import opmode_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_RAM_W  = 256,
    parameter int DATA_ROM_W  = 256,
    parameter int PROG_RAM_W  = 512,
    parameter int PERIPH_BASE = 'hFFC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pin_a,
    input  logic              mode_pin_b,
    input  logic              mode_pin_c,
    input  logic              upd_en,
    input  logic [2:0]        upd_op,
    input  logic [OMR_W-1:0]  upd_data,
    input  logic [OMR_BW-1:0] upd_bit,
    output logic [OMR_W-1:0]  omr_q,
    output logic              pins_are_irq,
    input  logic [ADDR_W-1:0] x_addr,
    output logic [SEL_W-1:0]  x_sel,
    output logic              x_ext,
    input  logic [ADDR_W-1:0] y_addr,
    output logic [SEL_W-1:0]  y_sel,
    output logic              y_ext,
    input  logic [ADDR_W-1:0] p_addr,
    output logic [SEL_W-1:0]  p_sel,
    output logic              p_ext
);
    logic prog_off;

    opmode_reg #(.W(OMR_W), .BW(OMR_BW)) reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_a    (mode_pin_a),
        .pin_b    (mode_pin_b),
        .pin_c    (mode_pin_c),
        .upd_en   (upd_en),
        .upd_op   (upd_op),
        .upd_data (upd_data),
        .upd_bit  (upd_bit),
        .omr_q    (omr_q),
        .pins_irq (pins_are_irq)
    );

    // Mode with B set and A clear has no internal program RAM.
    assign prog_off = omr_q[B_MB] && !omr_q[B_MA];

    addr_space_dec #(
        .ADDR_W(ADDR_W), .RAM_WORDS(DATA_RAM_W), .HAS_ROM(1'b1),
        .ROM_BASE(DATA_RAM_W), .ROM_WORDS(DATA_ROM_W),
        .HAS_PERIPH(1'b1), .PERIPH_BASE(PERIPH_BASE)
    ) x_dec_i (
        .addr(x_addr), .space_off(1'b0), .rom_en(omr_q[B_DE]),
        .sel(x_sel), .ext(x_ext)
    );

    addr_space_dec #(
        .ADDR_W(ADDR_W), .RAM_WORDS(DATA_RAM_W), .HAS_ROM(1'b1),
        .ROM_BASE(DATA_RAM_W), .ROM_WORDS(DATA_ROM_W),
        .HAS_PERIPH(1'b0), .PERIPH_BASE(PERIPH_BASE)
    ) y_dec_i (
        .addr(y_addr), .space_off(omr_q[B_YD]), .rom_en(omr_q[B_DE]),
        .sel(y_sel), .ext(y_ext)
    );

    addr_space_dec #(
        .ADDR_W(ADDR_W), .RAM_WORDS(PROG_RAM_W), .HAS_ROM(1'b0),
        .ROM_BASE(PROG_RAM_W), .ROM_WORDS(1),
        .HAS_PERIPH(1'b0), .PERIPH_BASE(PERIPH_BASE)
    ) p_dec_i (
        .addr(p_addr), .space_off(prog_off), .rom_en(1'b0),
        .sel(p_sel), .ext(p_ext)
    );
endmodule

// File: rtl/opmode_checker.sv
// Property checker for opmode_mem_decode, attached with bind below.
module opmode_checker
    import opmode_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_pin_a,
    input logic              mode_pin_b,
    input logic              mode_pin_c,
    input logic              upd_en,
    input logic [2:0]        upd_op,
    input logic [OMR_W-1:0]  upd_data,
    input logic [OMR_W-1:0]  omr_q,
    input logic              pins_are_irq,
    input logic [15:0]       x_addr,
    input logic [SEL_W-1:0]  x_sel,
    input logic              x_ext,
    input logic [SEL_W-1:0]  y_sel,
    input logic              y_ext,
    input logic [SEL_W-1:0]  p_sel,
    input logic              p_ext
);
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (omr_q & ~OMR_IMPL_MASK) == '0);

    p_pin_capture_r2: assert property (@(posedge clk)
        !rst_n |=> (omr_q[B_MA] == $past(mode_pin_a) && omr_q[B_MB] == $past(mode_pin_b)
                    && omr_q[B_MC] == $past(mode_pin_c)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(omr_q));

    p_reset_clear_r3: assert property (@(posedge clk)
        !rst_n |=> (!omr_q[B_DE] && !omr_q[B_YD] && !omr_q[B_SD]));

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_op == UPD_WRITE) |=> omr_q == ($past(upd_data) & OMR_IMPL_MASK));

    p_bad_op_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_op > UPD_BFLIP) |=> $stable(omr_q));

    p_periph_internal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (x_addr >= 16'hFFC0) |-> (x_sel == 4'b0100 && !x_ext));

    p_y_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        omr_q[B_YD] |-> (y_sel == 4'b1000 && y_ext));

    p_prog_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (omr_q[B_MB] && !omr_q[B_MA]) |-> (p_ext && p_sel == 4'b1000));

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(x_sel) == 1 && $countones(y_sel) == 1 && $countones(p_sel) == 1));

    p_irq_set_r11: assert property (@(posedge clk) rst_n |=> pins_are_irq);

    p_irq_clear_r11: assert property (@(posedge clk) !rst_n |=> !pins_are_irq);
endmodule

bind opmode_mem_decode opmode_checker chk_i (
    .clk(clk), .rst_n(rst_n), .mode_pin_a(mode_pin_a), .mode_pin_b(mode_pin_b),
    .mode_pin_c(mode_pin_c), .upd_en(upd_en), .upd_op(upd_op), .upd_data(upd_data),
    .omr_q(omr_q), .pins_are_irq(pins_are_irq), .x_addr(x_addr), .x_sel(x_sel),
    .x_ext(x_ext), .y_sel(y_sel), .y_ext(y_ext), .p_sel(p_sel), .p_ext(p_ext)
);

// File: tb/opmode_mem_decode_tb_top.sv
// Bench: reset capture for all pin patterns, an update-operation sequence
// against a bench model, and a full sweep of all three address spaces.
module opmode_mem_decode_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pa = 1'b0, pb = 1'b0, pc = 1'b0;
    logic        upd_en = 1'b0;
    logic [2:0]  upd_op = 3'd0;
    logic [23:0] upd_data = '0;
    logic [4:0]  upd_bit = '0;
    logic [23:0] omr_q;
    logic        pins_are_irq;
    logic [15:0] x_addr = '0, y_addr = '0, p_addr = '0;
    logic [3:0]  x_sel, y_sel, p_sel;
    logic        x_ext, y_ext, p_ext;

    int total = 0;
    int bad = 0;
    logic [23:0] model = '0;

    always #4 clk = ~clk;

    opmode_mem_decode dut_i (
        .clk(clk), .rst_n(rst_n), .mode_pin_a(pa), .mode_pin_b(pb), .mode_pin_c(pc),
        .upd_en(upd_en), .upd_op(upd_op), .upd_data(upd_data), .upd_bit(upd_bit),
        .omr_q(omr_q), .pins_are_irq(pins_are_irq),
        .x_addr(x_addr), .x_sel(x_sel), .x_ext(x_ext),
        .y_addr(y_addr), .y_sel(y_sel), .y_ext(y_ext),
        .p_addr(p_addr), .p_sel(p_sel), .p_ext(p_ext)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] apply_op(logic [23:0] cur, logic [2:0] op,
                                             logic [23:0] d, logic [4:0] b);
        logic [23:0] m;
        logic [23:0] r;
        m = (b < 5'd24) ? (24'd1 << b) : 24'd0;
        case (op)
            3'd0: r = d;
            3'd1: r = cur & d;
            3'd2: r = cur | d;
            3'd3: r = cur | m;
            3'd4: r = cur & ~m;
            3'd5: r = cur ^ m;
            default: r = cur;
        endcase
        return r & 24'h00005F;
    endfunction

    function automatic logic [3:0] exp_x(logic [15:0] a, logic de);
        if (a >= 16'hFFC0) return 4'b0100;
        if (a < 16'd256) return 4'b0001;
        if (a < 16'd512 && de) return 4'b0010;
        return 4'b1000;
    endfunction

    function automatic logic [3:0] exp_y(logic [15:0] a, logic de, logic yd);
        if (yd) return 4'b1000;
        if (a < 16'd256) return 4'b0001;
        if (a < 16'd512 && de) return 4'b0010;
        return 4'b1000;
    endfunction

    function automatic logic [3:0] exp_p(logic [15:0] a, logic ma, logic mb);
        if (mb && !ma) return 4'b1000;
        if (a < 16'd512) return 4'b0001;
        return 4'b1000;
    endfunction

    task automatic do_upd(input logic [2:0] op, input logic [23:0] d, input logic [4:0] b);
        @(negedge clk);
        upd_en = 1'b1; upd_op = op; upd_data = d; upd_bit = b;
        @(negedge clk);
        upd_en = 1'b0;
        model = apply_op(model, op, d, b);
        check("R4/R5 update", omr_q, model);
    endtask

    initial begin
        // Watchdog: an expired run counts as a failure.
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] exp_v;
        // Reset with every pin pattern; an update is held on through reset.
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            rst_n = 1'b1;
            upd_en = 1'b1; upd_op = 3'd0; upd_data = 24'hFFFFFF;
            @(negedge clk);
            check("R4 set gating bits before reset", omr_q, 24'h00005F);
            rst_n = 1'b0;
            pa = k[0]; pb = k[1]; pc = k[2];
            upd_data = 24'hFFFFFF;
            @(negedge clk);
            exp_v = '0;
            exp_v[0] = k[0]; exp_v[1] = k[1]; exp_v[4] = k[2];
            check("R3 reset clears DE/YD/SD", omr_q, exp_v);
            check("R11 irq flag low in reset", {23'd0, pins_are_irq}, 24'd0);
            @(negedge clk);
            rst_n = 1'b1;
            upd_en = 1'b0;
            @(negedge clk);
            check("R2 pin capture", omr_q, exp_v);
            check("R11 irq flag after release", {23'd0, pins_are_irq}, 24'd1);
            pa = ~pa; pb = ~pb; pc = ~pc;
            repeat (2) @(negedge clk);
            check("R2 pins ignored after reset", omr_q, exp_v);
            model = exp_v;
        end

        // Update operations against the model, including reserved bits and bad codes.
        do_upd(3'd0, 24'hABCDEF, 5'd0);
        do_upd(3'd2, 24'h000020, 5'd0);
        check("R1 reserved bit 5 stays zero", omr_q & 24'hFFFFA0, 24'd0);
        do_upd(3'd1, 24'hFFFFF3, 5'd0);
        do_upd(3'd3, 24'd0, 5'd2);
        do_upd(3'd3, 24'd0, 5'd5);
        do_upd(3'd5, 24'd0, 5'd6);
        do_upd(3'd5, 24'd0, 5'd0);
        do_upd(3'd4, 24'd0, 5'd2);
        do_upd(3'd3, 24'd0, 5'd30);
        do_upd(3'd6, 24'hFFFFFF, 5'd1);
        do_upd(3'd7, 24'h000000, 5'd1);
        do_upd(3'd2, 24'hFFFFFF, 5'd0);
        do_upd(3'd5, 24'd0, 5'd23);
        check("R1 only implemented bits", omr_q, 24'h00005F);

        // Decode sees an update only after the clock edge.
        do_upd(3'd0, 24'h000000, 5'd0);
        @(negedge clk);
        x_addr = 16'h0100;
        upd_en = 1'b1; upd_op = 3'd3; upd_bit = 5'd2;
        #1 check("R4 decode before edge", {20'd0, x_sel}, 24'h8);
        @(negedge clk);
        upd_en = 1'b0;
        model = apply_op(model, 3'd3, 24'd0, 5'd2);
        #1 check("R4 decode after edge", {20'd0, x_sel}, 24'h2);

        // Full address sweep under four register settings.
        for (int cfg = 0; cfg < 4; cfg++) begin
            logic [23:0] d;
            d = '0;
            d[0] = cfg[0]; d[1] = cfg[1]; d[2] = cfg[0]; d[3] = cfg[1];
            do_upd(3'd0, d, 5'd0);
            for (int a = 0; a < 65536; a++) begin
                logic [3:0] ex, ey, ep;
                x_addr = a[15:0]; y_addr = a[15:0]; p_addr = a[15:0];
                ex = exp_x(a[15:0], d[2]);
                ey = exp_y(a[15:0], d[2], d[3]);
                ep = exp_p(a[15:0], d[0], d[1]);
                #1;
                check("R6/R7/R8/R9/R10 decode",
                      {5'd0, x_ext, x_sel, 3'd0, y_ext, y_sel, 3'd0, p_ext, p_sel},
                      {5'd0, ex[3], ex, 3'd0, ey[3], ey, 3'd0, ep[3], ep});
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule